// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block decides when a successive-approximation converter runs a conversion and how long that conversion lasts. Software starts a single conversion by writing a one to a start bit. As an alternative, the block can be armed to start on a rising edge of one trigger line, picked from a bank of trigger sources. The start bit reads back high for the whole conversion, and hardware drops it at the end.

A clock divider sets the conversion pace. It divides the system clock by a power of two, and one conversion takes a fixed number of divided clock ticks. The sampling and the bit-by-bit comparison are not modelled. A tick counter stands in for them. The divider restarts at each accepted start, so every conversion takes the same number of system cycles whatever the phase of the start. The channel select is captured when a conversion starts and is held until the next one. When a conversion finishes, the block emits a one-cycle done strobe to the result registers and sets a sticky completion flag. An interrupt enable only masks the interrupt output; it never stops the flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `flag_o` and `irq_o` are 0 and `chan_o` is 0.
- R2: A cycle with `start_wr_i`=1 while enabled and idle makes `busy_o` read 1 from the next cycle on.
- R3: A conversion holds `busy_o` high for exactly 13 × 2^`prescale_i` clock cycles. The cycle after the last busy cycle has `done_o`=1 and `busy_o`=0, and `done_o` is high for that one cycle only.
- R4: Start writes that arrive while `busy_o` is 1 change neither the length of the running conversion nor the latched channel.
- R5: `chan_o` takes the value of `chan_sel_i` in the cycle a conversion is accepted and holds it until the next accepted start. A change to `chan_sel_i` during a conversion shows up only in the next conversion.
- R6: With `auto_en_i`=1, a rising edge on `trig_i[trig_sel_i]` starts a conversion, in the same way as a start write. Edges on trigger bits that are not selected are ignored. With `auto_en_i`=0, all trigger edges are ignored.
- R7: A trigger edge that arrives during a conversion is ignored. A trigger that is still high when a conversion completes does not start another one; a new start needs a fresh low-to-high transition.
- R8: An accepted start clears the divider, so the conversion length of R3 holds whatever the divider phase was before the start.
- R9: While `enable_i`=0, start writes and trigger edges are ignored and the divider is held cleared. Dropping `enable_i` during a conversion ends it in the next cycle with no `done_o`.
- R10: `flag_o` is set by `done_o` whatever the value of `irq_en_i`, stays set until a `flag_clr_i` pulse, and `irq_o` equals `flag_o` AND `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Converter enable; 0 powers the sequencer down |
| start_wr_i | input | 1 | One-cycle write of one to the start bit |
| auto_en_i | input | 1 | Arms start-on-trigger-edge |
| trig_sel_i | input | 3 | Index of the trigger source in use |
| trig_i | input | 8 | Bank of trigger source lines |
| prescale_i | input | 3 | Divider exponent, divide by 2^prescale_i |
| chan_sel_i | input | 4 | Requested input channel |
| irq_en_i | input | 1 | Interrupt mask for the completion flag |
| flag_clr_i | input | 1 | Clears the completion flag |
| busy_o | output | 1 | Start bit readback, high during a conversion |
| chan_o | output | 4 | Channel latched for the current or last conversion |
| done_o | output | 1 | One-cycle conversion-complete strobe |
| flag_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two cases are the hardest to reach from the ports: a trigger that is still high when a conversion ends, and a trigger edge that arrives partway through a conversion. The stimulus raises the selected trigger a few cycles into a short conversion and holds it high. It then watches past the done strobe and checks that no second conversion begins. Divider reset is reached by leaving the block idle for a number of cycles that is not a multiple of the division ratio, so the free-running divider is mid-phase. The bench then fires an edge and checks that the busy time still comes out to the exact product.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int unsigned CONV_TICKS_DEF = 13;
  typedef enum logic {ST_IDLE, ST_CONV} conv_state_e;
endpackage

// File: rtl/adc_trig_edge.sv
`timescale 1ns/1ps
module adc_trig_edge #(
  parameter int unsigned N_TRIG = 8,
  localparam int unsigned SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              rise_o
);
  logic trig_cur, trig_q;

  assign trig_cur = trig_i[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_cur;
  end

  assign rise_o = trig_cur & ~trig_q;
endmodule

// File: rtl/adc_prescaler.sv
`timescale 1ns/1ps
module adc_prescaler #(
  parameter int unsigned PS_W = 3,
  localparam int unsigned CNT_W = (1 << PS_W) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  logic [CNT_W-1:0] cnt_q, last;

  assign last   = ~({CNT_W{1'b1}} << sel_i);
  assign tick_o = ~clr_i & (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_conv_fsm.sv
`timescale 1ns/1ps
module adc_conv_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned CONV_TICKS = CONV_TICKS_DEF,
  parameter int unsigned CH_W = 4,
  localparam int unsigned TC_W = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            start_req_i,
  input  logic            tick_i,
  input  logic [CH_W-1:0] chan_sel_i,
  output logic            start_acc_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [CH_W-1:0] chan_o
);
  conv_state_e state_q;
  logic [TC_W-1:0] tcnt_q;
  logic last_tick;

  assign busy_o      = (state_q == ST_CONV);
  assign start_acc_o = enable_i & ~busy_o & start_req_i;
  assign last_tick   = busy_o & tick_i & (tcnt_q == TC_W'(CONV_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      done_o  <= 1'b0;
      chan_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!enable_i) begin
        state_q <= ST_IDLE;
        tcnt_q  <= '0;
      end else if (start_acc_o) begin
        state_q <= ST_CONV;
        tcnt_q  <= '0;
        chan_o  <= chan_sel_i;
      end else if (last_tick) begin
        state_q <= ST_IDLE;
        tcnt_q  <= '0;
        done_o  <= 1'b1;
      end else if (busy_o && tick_i) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_TRIG     = 8,
  parameter int unsigned PS_W       = 3,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned CONV_TICKS = CONV_TICKS_DEF,
  localparam int unsigned SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              start_wr_i,
  input  logic              auto_en_i,
  input  logic [SEL_W-1:0]  trig_sel_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [PS_W-1:0]   prescale_i,
  input  logic [CH_W-1:0]   chan_sel_i,
  input  logic              irq_en_i,
  input  logic              flag_clr_i,
  output logic              busy_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              done_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic trig_rise, start_req, start_acc, tick;

  adc_trig_edge #(.N_TRIG(N_TRIG)) edge_i (
    .clk_i, .rst_ni, .trig_i, .sel_i(trig_sel_i), .rise_o(trig_rise)
  );

  assign start_req = start_wr_i | (auto_en_i & trig_rise);

  // any accepted start or power-down restarts the divider phase
  adc_prescaler #(.PS_W(PS_W)) presc_i (
    .clk_i, .rst_ni, .clr_i(~enable_i | start_acc), .sel_i(prescale_i), .tick_o(tick)
  );

  adc_conv_fsm #(.CONV_TICKS(CONV_TICKS), .CH_W(CH_W)) fsm_i (
    .clk_i, .rst_ni, .enable_i, .start_req_i(start_req), .tick_i(tick),
    .chan_sel_i, .start_acc_o(start_acc), .busy_o, .done_o, .chan_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (done_o)     flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
  parameter int unsigned CH_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            enable_i,
  input logic            start_wr_i,
  input logic            auto_en_i,
  input logic            irq_en_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [CH_W-1:0] chan_o,
  input logic            flag_o,
  input logic            irq_o
);
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))) else $error("done without busy end"); // R3

  AST_FALL_IS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(enable_i)) |-> done_o) else $error("busy fell w/o done"); // R3

  AST_CHAN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(chan_o)) else $error("chan moved"); // R5

  AST_START_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(enable_i) && ($past(start_wr_i) || $past(auto_en_i))))
    else $error("start without request"); // R2

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !busy_o) else $error("busy while disabled"); // R9

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> flag_o) else $error("flag not set"); // R10

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i)) else $error("irq ungated"); // R10
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .start_wr_i(start_wr_i),
  .auto_en_i(auto_en_i), .irq_en_i(irq_en_i), .busy_o(busy_o), .done_o(done_o),
  .chan_o(chan_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, start_wr = 1'b0, auto_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic [2:0] trig_sel = '0, prescale = '0;
  logic [7:0] trig = '0;
  logic [3:0] chan_sel = '0;
  logic busy, done, flag, irq;
  logic [3:0] chan;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .start_wr_i(start_wr),
    .auto_en_i(auto_en), .trig_sel_i(trig_sel), .trig_i(trig), .prescale_i(prescale),
    .chan_sel_i(chan_sel), .irq_en_i(irq_en), .flag_clr_i(flag_clr),
    .busy_o(busy), .chan_o(chan), .done_o(done), .flag_o(flag), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // from the first busy negedge, count busy cycles; stop on the first idle one
  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sw_start();
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1 busy", busy, 0);
    chk_eq("R1 done", done, 0);
    chk_eq("R1 flag", flag, 0);
    chk_eq("R1 irq", irq, 0);
    chk_eq("R1 chan", chan, 0);
  endtask

  task automatic t_length(input int ps);
    int n;
    prescale = 3'(ps);
    sw_start();
    chk_eq("R2 busy after start", busy, 1);
    count_busy(n);
    chk_eq("R3 length", n, 13 << ps);
    chk_eq("R3 done strobe", done, 1);
    @(negedge clk);
    chk_eq("R3 done one cycle", done, 0);
  endtask

  task automatic t_restart_ignored();
    int n = 0;
    prescale = 3'd1;
    sw_start();
    while (busy && n < 2000) begin
      start_wr = (n == 5 || n == 17);
      n++;
      @(negedge clk);
    end
    start_wr = 1'b0;
    chk_eq("R4 length with extra writes", n, 26);
    chk_eq("R4 done", done, 1);
  endtask

  task automatic t_channel();
    int n;
    prescale = 3'd0;
    chan_sel = 4'd3;
    sw_start();
    chk_eq("R5 chan latched", chan, 3);
    idle(4);
    chan_sel = 4'd9;
    @(negedge clk);
    chk_eq("R5 chan held mid", chan, 3);
    count_busy(n);
    chk_eq("R5 chan after done", chan, 3);
    idle(2);
    sw_start();
    chk_eq("R5 new chan next conversion", chan, 9);
    count_busy(n);
  endtask

  task automatic t_trigger_select();
    int n;
    prescale = 3'd0;
    trig_sel = 3'd2;
    auto_en = 1'b0;
    trig[2] = 1'b1; @(negedge clk);
    chk_eq("R6 auto off ignored", busy, 0);
    trig[2] = 1'b0; idle(2);
    auto_en = 1'b1;
    trig[5] = 1'b1; @(negedge clk);
    chk_eq("R6 unselected ignored", busy, 0);
    trig[5] = 1'b0; idle(2);
    trig[2] = 1'b1; @(negedge clk);
    chk_eq("R6 selected edge starts", busy, 1);
    trig[2] = 1'b0;
    count_busy(n);
    chk_eq("R6 length", n, 13);
    auto_en = 1'b0; idle(2);
  endtask

  task automatic t_trigger_held();
    int n = 0, extra = 0;
    prescale = 3'd0;
    trig_sel = 3'd6;
    auto_en = 1'b1;
    sw_start();
    while (busy && n < 2000) begin
      if (n == 3) trig[6] = 1'b1;
      n++;
      @(negedge clk);
    end
    chk_eq("R7 edge mid conversion ignored", n, 13);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) extra++;
    end
    chk_eq("R7 held trigger no restart", extra, 0);
    trig[6] = 1'b0; @(negedge clk);
    trig[6] = 1'b1; @(negedge clk);
    chk_eq("R7 fresh edge starts", busy, 1);
    trig[6] = 1'b0;
    count_busy(n);
    auto_en = 1'b0;
  endtask

  task automatic t_prescaler_reset();
    int n;
    prescale = 3'd3;
    trig_sel = 3'd1;
    auto_en = 1'b1;
    idle(5);
    trig[1] = 1'b1; @(negedge clk);
    trig[1] = 1'b0;
    count_busy(n);
    chk_eq("R8 length from mid-phase trigger", n, 104);
    idle(3);
    sw_start();
    count_busy(n);
    chk_eq("R8 length from mid-phase write", n, 104);
    auto_en = 1'b0;
  endtask

  task automatic t_disable();
    prescale = 3'd0;
    enable = 1'b0;
    auto_en = 1'b1;
    trig_sel = 3'd0;
    sw_start();
    chk_eq("R9 write ignored when off", busy, 0);
    trig[0] = 1'b1; @(negedge clk);
    chk_eq("R9 trigger ignored when off", busy, 0);
    trig[0] = 1'b0; auto_en = 1'b0;
    enable = 1'b1; idle(2);
    sw_start();
    idle(4);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    chk_eq("R9 abort clears busy", busy, 0);
    chk_eq("R9 abort no done", done, 0);
    idle(20);
    chk_eq("R9 abort no flag", flag, 0);
    enable = 1'b1; idle(2);
  endtask

  task automatic t_flag();
    int n;
    prescale = 3'd0;
    irq_en = 1'b0;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk_eq("R10 flag cleared", flag, 0);
    sw_start();
    count_busy(n);
    @(negedge clk);
    chk_eq("R10 flag set while masked", flag, 1);
    chk_eq("R10 irq masked", irq, 0);
    irq_en = 1'b1; #0.1;
    chk_eq("R10 irq unmasked", irq, 1);
    idle(3);
    chk_eq("R10 flag sticky", flag, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk_eq("R10 flag clear", flag, 0);
    chk_eq("R10 irq drops", irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    idle(2);
    t_length(0);
    t_length(2);
    t_length(7);
    t_restart_ignored();
    t_channel();
    t_trigger_select();
    t_trigger_held();
    t_prescaler_reset();
    t_disable();
    t_flag();
    finish_run();
  end
endmodule